// File: doc/BRIEF.md
# Register Increment Execution Slice

This block is one execution slice of an 8-bit processor core. It owns a file of thirty-two 8-bit general registers, an 8-bit status byte and a word-addressed program counter. It takes 16-bit instruction words as a valid/ready stream. When a word encodes the register-increment instruction, the slice adds one to the register named inside the word and updates the arithmetic flags. Every accepted word, matching or not, moves the program counter on by one word.

A host port sits beside the instruction stream. It preloads registers and the status byte and reads them back. The read side is combinational and always available. A host write takes the single write port for its cycle, so while `host_we` is high `in_ready` is low and no instruction is taken. An instruction is consumed only on a cycle where both `in_valid` and `in_ready` are high. A producer holding `in_valid` under back-pressure keeps its word until that cycle.

Top module: `reg_inc_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the program counter, the status byte and all 32 registers to zero.
- R2: A word matches when (word AND 0xFE0F) equals 0x9403. Bits 8:4 of a matching word select the destination register, 0 to 31.
- R3: A matching word writes the old register value plus one, modulo 256, into the destination, one clock after acceptance. No other register changes.
- R4: Status bit 3 (overflow) is set exactly when the operand before incrementing was 0x7F, and is cleared otherwise.
- R5: Status bit 2 (negative) equals bit 7 of the result. Status bit 1 (zero) is set when the result is 0x00.
- R6: Status bit 4 (sign) equals negative XOR overflow after a matching word.
- R7: A matching word leaves status bits 0, 5, 6 and 7 at their previous values.
- R8: Every accepted word advances the program counter by exactly one. The counter holds on cycles with no accepted word.
- R9: An accepted word that does not match changes no register and no status bit.
- R10: `in_ready` is low while `host_we` is high. A word presented in that cycle is not consumed and has no effect.
- R11: A host write with `host_sel_status` low stores `host_wdata` into register `host_addr`. With it high, the write stores into the status byte. `host_rdata` shows register `host_raddr` in the same cycle, and `status` always shows the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Slice can take a word this cycle |
| in_word | input | 16 | Instruction word |
| host_we | input | 1 | Host write strobe |
| host_sel_status | input | 1 | Host write targets the status byte |
| host_addr | input | 5 | Host write register index |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | 5 | Host read register index |
| host_rdata | output | 8 | Register contents at host_raddr |
| status | output | 8 | Status byte |
| pc | output | 16 | Program counter, in words |

## Verification
Each wrong internal state shows up at the ports one clock after the accepted word that caused it.

A decode error writes the wrong register or leaves the right one stale. That is visible on `host_rdata` once every register is swept. A flag rule error shows directly on `status`. A miscounted program counter shows on `pc`.

Each word's effect is isolated by preloading and sweeping between words. As a result, a fault cannot hide behind a later instruction.

// File: rtl/inc_unit_pkg.sv
package inc_unit_pkg;
  localparam int DATA_W  = 8;
  localparam int REG_CNT = 32;
  localparam int IDX_W   = $clog2(REG_CNT);
  localparam int WORD_W  = 16;
  localparam int PC_W    = 16;
  localparam int IDX_LSB = 4;

  localparam logic [WORD_W-1:0] INC_MASK  = 16'hFE0F;
  localparam logic [WORD_W-1:0] INC_MATCH = 16'h9403;

  // status byte bit positions
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

  localparam logic [DATA_W-1:0] KEEP_MASK =
    DATA_W'((1 << FL_C) | (1 << FL_H) | (1 << FL_T) | (1 << FL_I));
endpackage

// File: rtl/inc_decode.sv
module inc_decode
  import inc_unit_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int IW = IDX_W
) (
  input  logic [W-1:0]  word,
  output logic          hit,
  output logic [IW-1:0] idx
);
  assign hit = (word & INC_MASK) == INC_MATCH;
  assign idx = word[IDX_LSB +: IW];
endmodule

// File: rtl/inc_flags.sv
module inc_flags
  import inc_unit_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] operand,
  input  logic [7:0]    old_status,
  output logic [DW-1:0] result,
  output logic [7:0]    new_status
);
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};

  logic ovf, neg, zer;

  always_comb begin
    result     = operand + DW'(1);
    ovf        = (operand == MAX_POS);
    neg        = result[DW-1];
    zer        = (result == '0);
    new_status = old_status;
    new_status[FL_V] = ovf;
    new_status[FL_N] = neg;
    new_status[FL_Z] = zer;
    new_status[FL_S] = neg ^ ovf;
  end
endmodule

// File: rtl/inc_regfile.sv
module inc_regfile
  import inc_unit_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int N  = REG_CNT,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] cells [N];

  for (genvar g = 0; g < N; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)
        cells[g] <= '0;
      else if (we && waddr == AW'(g))
        cells[g] <= wdata;
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> cells[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/reg_inc_unit.sv
module reg_inc_unit
  import inc_unit_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int N    = REG_CNT,
  parameter int WW   = WORD_W,
  parameter int PW   = PC_W,
  localparam int AW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [WW-1:0] in_word,
  input  logic          host_we,
  input  logic          host_sel_status,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [AW-1:0] host_raddr,
  output logic [DW-1:0] host_rdata,
  output logic [7:0]    status,
  output logic [PW-1:0] pc
);
  logic          fire, hit, exec_we, rf_we;
  logic [AW-1:0] idx, rf_waddr;
  logic [DW-1:0] operand, result, rf_wdata;
  logic [7:0]    status_q, status_nx;
  logic [PW-1:0] pc_q;

  assign in_ready = !host_we;
  assign fire     = in_valid && in_ready;

  inc_decode #(.W(WW), .IW(AW)) u_dec (
    .word (in_word),
    .hit  (hit),
    .idx  (idx)
  );

  inc_flags #(.DW(DW)) u_flags (
    .operand    (operand),
    .old_status (status_q),
    .result     (result),
    .new_status (status_nx)
  );

  assign exec_we  = fire && hit;
  assign rf_we    = (host_we && !host_sel_status) || exec_we;
  assign rf_waddr = host_we ? host_addr  : idx;
  assign rf_wdata = host_we ? host_wdata : result;

  inc_regfile #(.DW(DW), .N(N)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (idx),
    .rdata_a (operand),
    .raddr_b (host_raddr),
    .rdata_b (host_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      pc_q     <= '0;
    end else begin
      if (host_we && host_sel_status)
        status_q <= host_wdata[7:0];
      else if (exec_we)
        status_q <= status_nx;
      if (fire)
        pc_q <= pc_q + PW'(1);
    end
  end

  assign status = status_q;
  assign pc     = pc_q;

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> pc_q == $past(pc_q) + PW'(1));

  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(pc_q));

  // R10
  host_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    host_we |-> !in_ready);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    exec_we |=> status_q[FL_V] == ($past(operand) == 8'h7F));

  // R6
  sign_rule_chk: assert property (@(posedge clk) disable iff (rst)
    exec_we |=> status_q[FL_S] == (status_q[FL_N] ^ status_q[FL_V]));

  // R7
  keep_bits_chk: assert property (@(posedge clk) disable iff (rst)
    exec_we |=> (status_q & KEEP_MASK) == ($past(status_q) & KEEP_MASK));

  // R9
  nomatch_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !hit) |=> $stable(status_q));
endmodule

// File: tb/reg_inc_unit_test.sv
`timescale 1ns/1ps
module reg_inc_unit_test;
  logic        clk = 0;
  logic        rst;
  logic        in_valid, in_ready;
  logic [15:0] in_word;
  logic        host_we, host_sel_status;
  logic [4:0]  host_addr, host_raddr;
  logic [7:0]  host_wdata, host_rdata, status;
  logic [15:0] pc;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0]  m_reg [32];
  logic [7:0]  m_st;
  logic [15:0] m_pc;

  always #2 clk = ~clk;

  reg_inc_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .host_we(host_we), .host_sel_status(host_sel_status),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_raddr(host_raddr),
    .host_rdata(host_rdata), .status(status), .pc(pc)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic sweep(string tag);
    int bad = 0;
    for (int i = 0; i < 32; i++) begin
      host_raddr = 5'(i);
      #0.01;
      if (host_rdata !== m_reg[i]) begin
        bad++;
        $display("FAIL %s: r%0d got=%0h expected=%0h", tag, i, host_rdata, m_reg[i]);
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic host_write(bit sel, int a, logic [7:0] d);
    @(negedge clk);
    host_we = 1; host_sel_status = sel; host_addr = 5'(a); host_wdata = d;
    @(negedge clk);
    host_we = 0; host_sel_status = 0;
    if (sel) m_st = d; else m_reg[a] = d;
  endtask

  task automatic issue(logic [15:0] w);
    @(negedge clk);
    in_valid = 1; in_word = w;
    @(negedge clk);
    in_valid = 0;
    m_pc++;
  endtask

  // R2 R3 R4 R5 R6 R7 R8: one increment on a preloaded register
  task automatic t_inc(int d, logic [7:0] v, logic [7:0] st0);
    logic [7:0] res, exp_st;
    bit ov, ng;
    host_write(0, d, v);
    host_write(1, 0, st0);
    issue(16'h9403 | 16'(d << 4));
    res = v + 8'd1;
    ov  = (v == 8'h7F);
    ng  = res[7];
    exp_st = (st0 & 8'hE1) | {3'b0, ng ^ ov, ov, ng, res == 0, 1'b0};
    m_reg[d] = res;
    m_st = exp_st;
    chk($sformatf("R3 r%0d value from %0h", d, v), 0, 0);
    checks--;
    sweep($sformatf("R3 R2 registers after inc r%0d v=%0h", d, v));
    chk($sformatf("R4 R5 R6 R7 status after inc r%0d v=%0h", d, v), status, exp_st);
    chk("R8 pc after inc", pc, m_pc);
  endtask

  // R9: non-matching word
  task automatic t_nomatch(logic [15:0] w);
    issue(w);
    sweep($sformatf("R9 registers after word %0h", w));
    chk($sformatf("R9 status after word %0h", w), status, m_st);
    chk("R8 pc after non-matching word", pc, m_pc);
  endtask

  // R10: host write and instruction in the same cycle
  task automatic t_backpressure();
    @(negedge clk);
    host_we = 1; host_sel_status = 0; host_addr = 5'd9; host_wdata = 8'h3C;
    in_valid = 1; in_word = 16'h9493;
    #0.01;
    chk("R10 in_ready low during host write", in_ready, 0);
    @(negedge clk);
    host_we = 0; in_valid = 0;
    m_reg[9] = 8'h3C;
    chk("R10 pc held while blocked", pc, m_pc);
    sweep("R10 R11 registers after blocked word");
    chk("R10 status after blocked word", status, m_st);
  endtask

  // R11: host access paths
  task automatic t_host();
    host_write(0, 31, 8'h5A);
    host_write(0, 0, 8'hA5);
    host_write(1, 0, 8'hC3);
    sweep("R11 host register writes");
    chk("R11 status write", status, 8'hC3);
    chk("R11 pc unaffected by host", pc, m_pc);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: got=%0d expected<=100000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] vals [7] = '{8'h00, 8'hFF, 8'hAA, 8'hF0, 8'h01, 8'h7F, 8'h80};
    in_valid = 0; in_word = 0; host_we = 0; host_sel_status = 0;
    host_addr = 0; host_wdata = 0; host_raddr = 0;
    rst = 1;
    for (int i = 0; i < 32; i++) m_reg[i] = 8'h00;
    m_st = 0; m_pc = 0;
    repeat (3) @(negedge clk);
    host_we = 1; host_wdata = 8'hEE;
    @(negedge clk);
    rst = 0; host_we = 0;
    // R1
    sweep("R1 registers after reset");
    chk("R1 status after reset", status, 0);
    chk("R1 pc after reset", pc, 0);

    t_host();
    for (int k = 0; k < 7; k++) begin
      t_inc(k * 5, vals[k], 8'h00);
      t_inc(31 - k, vals[k], 8'hFF);
    end
    t_inc(0, 8'h7F, 8'hE1);
    t_inc(16, 8'hFF, 8'h1E);
    t_nomatch(16'h9402);
    t_nomatch(16'h9C03);
    t_nomatch(16'h0000);
    t_nomatch(16'hFFFF);
    t_backpressure();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule